// File: doc/BRIEF.md
# Processor-side LL/SC link register

This block sits between a processor and the memory side of an L1 cache controller and handles the two halves of a load-linked / store-conditional pair. A load-linked request goes to memory as a reservation request. When the reply comes back, the block stores the address and the key that the memory side returns, and it passes the loaded word back to the processor.

A later store-conditional to the same address goes to memory as a conditional write. The command carries the address, the stored key and the write data. The memory side answers with a status word, where zero means the write happened. The block turns that status into the processor's convention: 1 in the destination register on success, 0 on failure.

A store-conditional that cannot succeed is answered inside the block, with no memory traffic. This covers an address that differs from the linked one, and the case where no link is held. Only one memory transaction is in flight at a time. The processor port stays not-ready until that transaction's reply has arrived.

Top module: `llsc_link`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mcmd_valid` are 0, and no link is held: a store-conditional issued first fails locally.
- R2: An accepted load-linked request (`req_sc`=0) raises `mcmd_valid` in the next cycle, with `mcmd_sc`=0 and `mcmd_addr` equal to the request address.
- R3: A load-linked reply returns `mresp_data` unchanged on `rsp_data`. It stores the request address and `mresp_key` as the link, replacing any earlier link.
- R4: An accepted store-conditional (`req_sc`=1) to the linked address raises `mcmd_valid` with `mcmd_sc`=1, the request address, the request data, and the key stored by the latest load-linked reply.
- R5: For a forwarded store-conditional, a `mresp_data` of 0 (success) gives `rsp_data`=1. Any nonzero `mresp_data` (failure) gives `rsp_data`=0.
- R6: Any completed store-conditional clears the link, whether it succeeded, failed in memory or failed locally. A following store-conditional to the same address then fails locally.
- R7: A store-conditional whose address differs from the linked address gets `rsp_valid` with `rsp_data`=0 in the cycle after acceptance, and `mcmd_valid` stays 0.
- R8: A store-conditional while no link is held fails locally in the same way as R7.
- R9: From acceptance until the memory reply, `req_ready` is 0. While `mcmd_valid` is 1 and `mcmd_ready` is 0, the command stays valid and its fields stay stable.
- R10: Each accepted request produces exactly one one-cycle `rsp_valid` pulse. For a forwarded request, the pulse comes one cycle after `mresp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_sc | input | 1 | 1 = store-conditional, 0 = load-linked |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store-conditional data |
| rsp_valid | output | 1 | One-cycle processor response |
| rsp_data | output | DW | Loaded word, or 1/0 store-conditional result |
| mcmd_valid | output | 1 | Memory command present |
| mcmd_ready | input | 1 | Memory side takes the command |
| mcmd_sc | output | 1 | 1 = conditional write, 0 = reservation request |
| mcmd_addr | output | AW | Command address |
| mcmd_key | output | KW | Stored reservation key |
| mcmd_wdata | output | DW | Conditional write data |
| mresp_valid | input | 1 | Memory reply present |
| mresp_data | input | DW | Loaded word or status (0 = success) |
| mresp_key | input | KW | Key returned with a reservation reply |

## Verification
The hardest case to reach from the ports is the cleared link. A failed store-conditional of any kind must leave the block with no link, and that state is visible only through the next store-conditional. Each scenario therefore follows a store-conditional with a second one to the same address. The bench checks that this second one is answered locally, one cycle after acceptance, with no memory command. A memory side that holds off `mcmd_ready` for several cycles exercises the stall and command-stability rule.

// File: rtl/llsc_link.sv
module llsc_link #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int KW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_sc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mcmd_valid,
  input  logic          mcmd_ready,
  output logic          mcmd_sc,
  output logic [AW-1:0] mcmd_addr,
  output logic [KW-1:0] mcmd_key,
  output logic [DW-1:0] mcmd_wdata,
  input  logic          mresp_valid,
  input  logic [DW-1:0] mresp_data,
  input  logic [KW-1:0] mresp_key
);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WAIT} st_t;

  st_t           st;
  logic          op_sc;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          link_v;
  logic [AW-1:0] link_addr;
  logic [KW-1:0] link_key;

  wire take      = req_valid && req_ready;
  wire link_hit  = link_v && (req_addr == link_addr);
  wire local_nak = take && req_sc && !link_hit;
  wire got_rsp   = (st == ST_WAIT) && mresp_valid;

  assign req_ready  = (st == ST_IDLE);
  assign mcmd_valid = (st == ST_CMD);
  assign mcmd_sc    = op_sc;
  assign mcmd_addr  = addr_q;
  assign mcmd_key   = link_key;
  assign mcmd_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_sc     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      link_v    <= 1'b0;
      link_addr <= '0;
      link_key  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (local_nak) begin
            link_v    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= '0;
          end else if (take) begin
            op_sc   <= req_sc;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            st      <= ST_CMD;
          end
        end
        ST_CMD: if (mcmd_ready) st <= ST_WAIT;
        ST_WAIT: begin
          if (got_rsp) begin
            rsp_valid <= 1'b1;
            st        <= ST_IDLE;
            if (op_sc) begin
              link_v   <= 1'b0;
              rsp_data <= {{(DW-1){1'b0}}, (mresp_data == '0)};
            end else begin
              link_v    <= 1'b1;
              link_addr <= addr_q;
              link_key  <= mresp_key;
              rsp_data  <= mresp_data;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/llsc_link_chk.sv
module llsc_link_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int KW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_sc,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          mcmd_valid,
  input logic          mcmd_ready,
  input logic          mcmd_sc,
  input logic [AW-1:0] mcmd_addr,
  input logic [DW-1:0] mcmd_wdata,
  input logic          mresp_valid,
  input logic [DW-1:0] mresp_data,
  input logic          link_v,
  input logic [AW-1:0] link_addr
);

  logic waiting, pend_sc;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      pend_sc <= 1'b0;
    end else begin
      if (mcmd_valid && mcmd_ready) begin
        waiting <= 1'b1;
        pend_sc <= mcmd_sc;
      end else if (mresp_valid) begin
        waiting <= 1'b0;
      end
    end
  end

  wire done_sc = waiting && mresp_valid && pend_sc;
  wire sc_miss = req_valid && req_ready && req_sc && !(link_v && req_addr == link_addr);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mcmd_valid && !mcmd_ready |=> mcmd_valid && $stable(mcmd_addr) && $stable(mcmd_wdata) && $stable(mcmd_sc)); // R9
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mcmd_valid || waiting) |-> !req_ready); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_LOCAL_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    sc_miss |=> rsp_valid && rsp_data == '0 && !mcmd_valid); // R7
  AST_SC_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
    mcmd_valid && mcmd_sc |-> link_v && mcmd_addr == link_addr); // R4
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_sc |=> !link_v); // R6
  AST_XCODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_sc |=> rsp_valid && rsp_data == {{(DW-1){1'b0}}, ($past(mresp_data) == '0)}); // R5

endmodule

bind llsc_link llsc_link_chk #(.AW(AW), .DW(DW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_sc(req_sc), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .mcmd_valid(mcmd_valid), .mcmd_ready(mcmd_ready), .mcmd_sc(mcmd_sc),
  .mcmd_addr(mcmd_addr), .mcmd_wdata(mcmd_wdata), .mresp_valid(mresp_valid),
  .mresp_data(mresp_data), .link_v(link_v), .link_addr(link_addr)
);

// File: tb/test_llsc_link.sv
module test_llsc_link;
  localparam int AW = 32, DW = 32, KW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_sc = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mcmd_valid, mcmd_sc;
  logic [DW-1:0] rsp_data, mcmd_wdata;
  logic [AW-1:0] mcmd_addr;
  logic [KW-1:0] mcmd_key;
  logic mcmd_ready = 1'b0, mresp_valid = 1'b0;
  logic [DW-1:0] mresp_data = '0;
  logic [KW-1:0] mresp_key = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  llsc_link #(.AW(AW), .DW(DW), .KW(KW)) i_llsc_link (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sc(req_sc), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mcmd_valid(mcmd_valid),
    .mcmd_ready(mcmd_ready), .mcmd_sc(mcmd_sc), .mcmd_addr(mcmd_addr),
    .mcmd_key(mcmd_key), .mcmd_wdata(mcmd_wdata), .mresp_valid(mresp_valid),
    .mresp_data(mresp_data), .mresp_key(mresp_key)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(bit sc, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    check("R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_sc = sc; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory side: check command, accept after 'hold' stalled cycles, reply
  task automatic mem_turn(string req, bit sc, logic [AW-1:0] a, logic [KW-1:0] k,
                          logic [DW-1:0] d, int hold, logic [DW-1:0] rd,
                          logic [KW-1:0] rk);
    check({req, " cmd valid"}, mcmd_valid, 1);
    check({req, " cmd kind"}, mcmd_sc, sc);
    check({req, " cmd addr"}, mcmd_addr, a);
    if (sc) begin
      check("R4 cmd key", mcmd_key, k);
      check("R4 cmd data", mcmd_wdata, d);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R9 cmd held", mcmd_valid, 1);
      check("R9 addr stable", mcmd_addr, a);
      check("R9 stall", req_ready, 0);
    end
    mcmd_ready = 1'b1;
    @(negedge clk);
    mcmd_ready = 1'b0;
    check("R9 busy after handshake", req_ready, 0);
    mresp_valid = 1'b1; mresp_data = rd; mresp_key = rk;
    @(negedge clk);
    mresp_valid = 1'b0;
    check("R10 rsp pulse", rsp_valid, 1);
  endtask

  task automatic do_ll(logic [AW-1:0] a, logic [DW-1:0] rd, logic [KW-1:0] rk, int hold);
    send(1'b0, a, '0);
    mem_turn("R2", 1'b0, a, '0, '0, hold, rd, rk);
    check("R3 loaded word", rsp_data, rd);
    @(negedge clk);
    check("R10 rsp single", rsp_valid, 0);
  endtask

  task automatic do_sc_mem(logic [AW-1:0] a, logic [DW-1:0] d, logic [KW-1:0] k,
                           logic [DW-1:0] status, logic [DW-1:0] exp);
    send(1'b1, a, d);
    mem_turn("R4", 1'b1, a, k, d, 0, status, '0);
    check("R5 transcoded result", rsp_data, exp);
    @(negedge clk);
    check("R10 rsp single", rsp_valid, 0);
  endtask

  task automatic do_sc_local(string req, logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_sc = 1'b1; req_addr = a; req_wdata = 'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " local rsp"}, rsp_valid, 1);
    check({req, " local result"}, rsp_data, 0);
    check({req, " no mem cmd"}, mcmd_valid, 0);
    @(negedge clk);
    check({req, " still no cmd"}, mcmd_valid, 0);
    check("R10 rsp single", rsp_valid, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 ready", req_ready, 1);
    check("R1 rsp idle", rsp_valid, 0);
    check("R1 cmd idle", mcmd_valid, 0);
    do_sc_local("R1 R8 no link", 32'h100);
  endtask

  task automatic t_success;
    do_ll(32'h100, 32'h0, 32'hA1A1, 0);
    do_sc_mem(32'h100, 32'h1, 32'hA1A1, 32'h0, 32'h1);
    do_sc_local("R6 after success", 32'h100);
  endtask

  task automatic t_mismatch;
    do_ll(32'h200, 32'h55, 32'hB2B2, 0);
    do_sc_local("R7 other addr", 32'h204);
    do_sc_local("R6 after local fail", 32'h200);
  endtask

  task automatic t_mem_fail;
    do_ll(32'h300, 32'h0, 32'hC3C3, 0);
    do_sc_mem(32'h300, 32'h7, 32'hC3C3, 32'h1, 32'h0);
    do_sc_local("R6 after mem fail", 32'h300);
    do_ll(32'h300, 32'h9, 32'hC4C4, 0);
    do_sc_mem(32'h300, 32'h8, 32'hC4C4, 32'h2, 32'h0);
  endtask

  task automatic t_stall_relink;
    do_ll(32'h400, 32'h11, 32'hD4D4, 3);
    do_ll(32'h500, 32'h22, 32'hE5E5, 2);
    do_sc_local("R3 old link replaced", 32'h400);
    do_ll(32'h500, 32'h33, 32'hF6F6, 0);
    do_sc_mem(32'h500, 32'hABCD, 32'hF6F6, 32'h0, 32'h1);
  endtask

  initial begin
    t_reset();
    t_success();
    t_mismatch();
    t_mem_fail();
    t_stall_relink();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule